// File: doc/BRIEF.md
# Edge-Interval Bit Check Validator

This block decides whether a demodulated serial stream comes from a real transmitter or is only noise. It times the gap between successive edges of the incoming signal in units of a slow tick. The tick comes from dividing the system clock. Each gap is taken as one half bit and is compared with a programmable lower and upper limit. A gap that is too short fails the check at the edge that ends it. A gap that grows to the upper limit fails the check at the moment the limit is reached, without waiting for an edge.

A wake-up sequencer enables the block and watches two one-cycle pulses. A fail pulse lets the sequencer put the receiver back to sleep. A pass pulse marks the change into receiving mode. The block enters receiving mode after a programmed number of consecutive good intervals, and it stays there, whatever the data does, until the sequencer asks for polling again or drops the enable.

Top module: `bitcheck_validator`

## Requirements
- R1: After reset, and before enable is raised, `rx_mode`, `pass_pulse` and `fail_pulse` are all 0.
- R2: While checking and armed, an edge that arrives when the interval count is below `lim_lo` gives one `fail_pulse` and clears the good-interval count. That edge starts the next measurement.
- R3: While checking and armed, the failure is declared as soon as the interval count reaches `lim_hi` with no edge: one `fail_pulse` follows, and the block disarms.
- R4: An interval whose count lies in [`lim_lo`, `lim_hi`) counts as one good interval. When the number of consecutive good intervals reaches `bits_req`, one `pass_pulse` is issued and `rx_mode` goes to 1 in the same cycle.
- R5: Any failure restarts the good-interval count from zero, so a full `bits_req` of new good intervals is needed before a pass.
- R6: While `rx_mode` is 1, edges, short gaps and long gaps have no effect. No pulse is issued, and `rx_mode` stays 1 until `poll_req` is seen or enable drops.
- R7: `poll_req` high in receiving mode returns the block to checking mode (`rx_mode` 0) in the next cycle, disarmed.
- R8: `enable` low forces the block idle within one cycle: `rx_mode` is 0, no pulses are issued, and all counters are cleared.
- R9: The first edge in checking mode only arms the measurement. It is not counted. While unarmed, no timeout fail can occur.
- R10: `pass_pulse` and `fail_pulse` are never high together, and each lasts exactly one cycle.
- R11: A `bits_req` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds it idle |
| dem_in | input | 1 | Demodulated data, asynchronous, passed through a two-flop synchronizer |
| lim_lo | input | LIM_W | Lowest acceptable interval count, in ticks |
| lim_hi | input | LIM_W | Interval count at which the check fails |
| bits_req | input | BITS_W | Consecutive good intervals needed to pass |
| poll_req | input | 1 | Return to checking (polling) mode |
| rx_mode | output | 1 | 1 while in receiving mode |
| pass_pulse | output | 1 | One-cycle pulse on a successful check |
| fail_pulse | output | 1 | One-cycle pulse on a failed interval |

## Verification
The bench first sends a failure in the middle of a run and then checks that the next pass needs three fresh good intervals. A design that kept the count across the failure would reach receiving mode one interval early. The bench also holds the line quiet for a long time, both after a timeout and in receiving mode. A design that timed out while unarmed would repeat its fail pulses, and one that kept checking in receiving mode would raise fail or drop `rx_mode`. Finally, the bench drops enable while the block is in receiving mode and sets the required count to zero, where a design without the zero guard would never pass.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_CHECK = 2'd1,
    MODE_RECV  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    IV_NONE  = 2'd0,
    IV_SHORT = 2'd1,
    IV_GOOD  = 2'd2,
    IV_LONG  = 2'd3
  } iv_e;

endpackage

// File: rtl/bchk_edge_sync.sv
module bchk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_d[g] = din;
      end else begin : g_rest
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/bchk_tick_gen.sv
module bchk_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/bchk_interval_timer.sv
module bchk_interval_timer
  import bchk_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             edge_i,
  input  logic [LIM_W-1:0] lim_lo,
  input  logic [LIM_W-1:0] lim_hi,
  output iv_e              iv_cls
);
  localparam logic [LIM_W-1:0] CNT_MAX = '1;

  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    iv_cls  = IV_NONE;
    if (clr) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (armed_q && (cnt_q >= lim_hi)) begin
      iv_cls  = IV_LONG;
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (edge_i) begin
      cnt_d   = '0;
      armed_d = 1'b1;
      if (armed_q) iv_cls = (cnt_q < lim_lo) ? IV_SHORT : IV_GOOD;
    end else if (armed_q && tick && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  AST_UNARMED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (cnt_q == '0)) else $error("count moved while unarmed"); // R9
  AST_CLASS_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_cls != IV_NONE) |-> armed_q) else $error("interval classified unarmed"); // R9
  AST_LONG_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_cls == IV_LONG) |=> !armed_q) else $error("still armed after timeout"); // R3

endmodule

// File: rtl/bchk_mode_ctrl.sv
module bchk_mode_ctrl
  import bchk_pkg::*;
#(
  parameter int BITS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              poll_req,
  input  logic [BITS_W-1:0] bits_req,
  input  iv_e               iv_cls,
  output logic              timer_clr,
  output logic              rx_mode,
  output logic              pass_pulse,
  output logic              fail_pulse
);
  localparam int GW = BITS_W + 1;

  mode_e            state_q, state_d;
  logic [GW-1:0]    good_q, good_d;
  logic             pass_q, pass_d;
  logic             fail_q, fail_d;
  logic [GW-1:0]    req_eff;

  assign req_eff = (bits_req == '0) ? GW'(1) : {1'b0, bits_req};

  always_comb begin
    state_d = state_q;
    good_d  = good_q;
    pass_d  = 1'b0;
    fail_d  = 1'b0;
    if (!enable) begin
      state_d = MODE_IDLE;
      good_d  = '0;
    end else begin
      unique case (state_q)
        MODE_IDLE: begin
          state_d = MODE_CHECK;
          good_d  = '0;
        end
        MODE_CHECK: begin
          if (poll_req) begin
            good_d = '0;
          end else begin
            unique case (iv_cls)
              IV_SHORT, IV_LONG: begin
                fail_d = 1'b1;
                good_d = '0;
              end
              IV_GOOD: begin
                if ((good_q + 1'b1) >= req_eff) begin
                  pass_d  = 1'b1;
                  state_d = MODE_RECV;
                  good_d  = '0;
                end else begin
                  good_d = good_q + 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        MODE_RECV: begin
          if (poll_req) state_d = MODE_CHECK;
        end
        default: state_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_IDLE;
      good_q  <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  assign timer_clr  = !enable || (state_q != MODE_CHECK) || poll_req;
  assign rx_mode    = (state_q == MODE_RECV);
  assign pass_pulse = pass_q;
  assign fail_pulse = fail_q;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q)) else $error("pass and fail together"); // R10
  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |=> !pass_q) else $error("pass longer than one cycle"); // R10
  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> !fail_q) else $error("fail longer than one cycle"); // R10
  AST_PASS_ENTERS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> (state_q == MODE_RECV)) else $error("pass without receiving mode"); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_RECV) && enable && !poll_req |=> (state_q == MODE_RECV))
    else $error("left receiving mode unasked"); // R6
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_RECV) && !$past(state_q == MODE_CHECK) |-> !fail_q && !pass_q)
    else $error("pulse in receiving mode"); // R6
  AST_POLL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_RECV) && poll_req && enable |=> (state_q == MODE_CHECK))
    else $error("poll request ignored"); // R7
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state_q == MODE_IDLE) && !pass_q && !fail_q && (good_q == '0))
    else $error("not idle after enable low"); // R8
  AST_GOOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_CHECK) && $stable(bits_req) |-> (good_q < req_eff))
    else $error("good count overran target"); // R4

endmodule

// File: rtl/bitcheck_validator.sv
module bitcheck_validator
  import bchk_pkg::*;
#(
  parameter int LIM_W    = 8,
  parameter int BITS_W   = 6,
  parameter int TICK_DIV = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              dem_in,
  input  logic [LIM_W-1:0]  lim_lo,
  input  logic [LIM_W-1:0]  lim_hi,
  input  logic [BITS_W-1:0] bits_req,
  input  logic              poll_req,
  output logic              rx_mode,
  output logic              pass_pulse,
  output logic              fail_pulse
);
  logic edge_w;
  logic tick_w;
  logic clr_w;
  iv_e  cls_w;

  bchk_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (dem_in),
    .edge_o (edge_w)
  );

  bchk_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .tick  (tick_w)
  );

  bchk_interval_timer #(.LIM_W(LIM_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_w),
    .tick   (tick_w),
    .edge_i (edge_w),
    .lim_lo (lim_lo),
    .lim_hi (lim_hi),
    .iv_cls (cls_w)
  );

  bchk_mode_ctrl #(.BITS_W(BITS_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .poll_req   (poll_req),
    .bits_req   (bits_req),
    .iv_cls     (cls_w),
    .timer_clr  (clr_w),
    .rx_mode    (rx_mode),
    .pass_pulse (pass_pulse),
    .fail_pulse (fail_pulse)
  );

  AST_TOP_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !rx_mode && !pass_pulse && !fail_pulse)
    else $error("activity while disabled"); // R1

endmodule

// File: tb/tb_bitcheck_validator.sv
module tb_bitcheck_validator;
  localparam int LIM_W  = 8;
  localparam int BITS_W = 6;
  localparam int DIV    = 4;
  localparam int GOOD   = 18;
  localparam int SHORT  = 8;
  localparam int LONG   = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              enable;
  logic              dem_in;
  logic [LIM_W-1:0]  lim_lo;
  logic [LIM_W-1:0]  lim_hi;
  logic [BITS_W-1:0] bits_req;
  logic              poll_req;
  logic              rx_mode, pass_pulse, fail_pulse;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  mon_on   = 1'b0;
  byte exp_q[$];

  always #5 clk = ~clk;

  bitcheck_validator #(.LIM_W(LIM_W), .BITS_W(BITS_W), .TICK_DIV(DIV), .SYNC_N(2)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dem_in(dem_in),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .bits_req(bits_req), .poll_req(poll_req),
    .rx_mode(rx_mode), .pass_pulse(pass_pulse), .fail_pulse(fail_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected pulses and compares
  always @(negedge clk) begin
    if (mon_on && (pass_pulse || fail_pulse)) begin
      byte got;
      got = pass_pulse ? "P" : "F";
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R9 unexpected pulse", got, 0);
      end else begin
        byte want;
        want = exp_q.pop_front();
        chk(got == want, "R2/R3/R4 pulse kind", got, want);
      end
      chk(!(pass_pulse && fail_pulse), "R10 exclusive", 1, 0);
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic toggle_after(input int n);
    wait_ticks(n);
    dem_in = ~dem_in;
  endtask

  task automatic settle_and_drain(input string req);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; dem_in = 1'b0; poll_req = 1'b0;
    lim_lo = 8'd14; lim_hi = 8'd24; bits_req = 6'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!rx_mode && !pass_pulse && !fail_pulse, "R1 reset state",
        {rx_mode, pass_pulse, fail_pulse}, 0);
    mon_on = 1'b1;
    enable = 1'b1;
    repeat (4) @(negedge clk);

    // R4 + R9: arm, then three good intervals
    toggle_after(2);
    toggle_after(GOOD);
    toggle_after(GOOD);
    repeat (10) @(negedge clk);
    chk(!rx_mode, "R9 first edge not counted", rx_mode, 0);
    exp_q.push_back("P");
    toggle_after(GOOD - 3);
    settle_and_drain("R4 pass pulse seen");
    chk(rx_mode, "R4 receiving mode", rx_mode, 1);

    // R6: noise in receiving mode
    toggle_after(SHORT);
    toggle_after(LONG);
    toggle_after(2);
    settle_and_drain("R6 no pulses in receiving mode");
    chk(rx_mode, "R6 receiving mode held", rx_mode, 1);

    // R7: poll request
    poll_req = 1'b1;
    @(negedge clk);
    poll_req = 1'b0;
    chk(!rx_mode, "R7 back to checking", rx_mode, 0);

    // R2: arm, good, short
    toggle_after(2);
    toggle_after(GOOD);
    exp_q.push_back("F");
    toggle_after(SHORT);
    settle_and_drain("R2 short interval fails");

    // R5: count restarted; two goods do not pass, third does
    toggle_after(GOOD - 3);
    toggle_after(GOOD);
    repeat (10) @(negedge clk);
    chk(!rx_mode, "R5 count cleared by failure", rx_mode, 0);
    exp_q.push_back("P");
    toggle_after(GOOD - 3);
    settle_and_drain("R5 pass after full run");
    chk(rx_mode, "R5 receiving mode", rx_mode, 1);

    // R8: enable low leaves receiving mode
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rx_mode, "R8 idle when disabled", rx_mode, 0);
    toggle_after(GOOD);
    repeat (5) @(negedge clk);
    chk(!pass_pulse && !fail_pulse && !rx_mode, "R8 quiet when disabled",
        {pass_pulse, fail_pulse}, 0);
    enable = 1'b1;
    repeat (4) @(negedge clk);

    // R3 + R9: arm, good, then silence
    toggle_after(2);
    toggle_after(GOOD);
    exp_q.push_back("F");
    wait_ticks(LONG);
    chk(exp_q.size() == 0, "R3 timeout fail", exp_q.size(), 0);
    wait_ticks(LONG);
    chk(exp_q.size() == 0 && !rx_mode, "R9 no timeout while unarmed", rx_mode, 0);

    // R11: zero required count behaves as one
    bits_req = 6'd0;
    toggle_after(2);
    exp_q.push_back("P");
    toggle_after(GOOD);
    settle_and_drain("R11 zero means one");
    chk(rx_mode, "R11 receiving mode", rx_mode, 1);

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule